// File: doc/BRIEF.md
# Per-Receiver Code Setup Arbiter

This block sits between the senders and the receivers of a shared-medium network in which every receiver decodes with a code chosen per sender. Each of the nodes may raise a request naming one destination node. For every destination the arbiter picks one sender and drives a setup strobe with that sender's number to the receiver. It waits for the receiver to acknowledge that its decoder is ready, and only then grants the sender. The destination stays owned by that sender until the sender lowers its request.

Each destination runs its own arbitration, so requests aimed at different receivers never wait on each other and can be granted in the same cycle. Inside one destination, senders are served in order of arrival. Senders that arrive in the same cycle are ordered round-robin, starting just after the sender that destination served last.

Top module: `code_setup_arbiter`

## Requirements
- R1: After reset, no sender is granted and no receiver sees a setup strobe.
- R2: A sender is granted only after its destination receiver has shown the setup strobe carrying that sender's number and has returned its acknowledge. With the acknowledge already high, a request applied before clock edge 1 shows setup after edge 2 and grant after edge 3.
- R3: While the acknowledge stays low, the setup strobe stays high, the announced sender number stays stable, and no grant is issued.
- R4: At most one sender is granted to a given receiver at any time.
- R5: Senders that reach the same destination in the same cycle are served round-robin. The order starts at the node after the one that destination last granted, wrapping from node 5 to node 0. After reset, the last granted node counts as node 5.
- R6: Senders that reach the same destination in different cycles are served in order of arrival, whatever their node numbers.
- R7: Requests to different destinations proceed in parallel. Three disjoint sender/receiver pairs requested together are all granted in the same cycle.
- R8: A grant holds for as long as the sender keeps its request. It drops one cycle after the request falls, and the destination then moves on to the next queued sender.
- R9: A request whose 3-bit destination field (bits 3i+2..3i of `req_dest` for sender i) names the sender itself, or a value above 5, is ignored: no setup strobe and no grant result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 6 | Per-sender request; held until the grant is done with |
| req_dest | input | 18 | Per-sender destination node, 3 bits per sender |
| rx_ack | input | 6 | Per-receiver acknowledge: decoding code is ready |
| grant | output | 6 | Per-sender grant to transmit |
| rx_setup | output | 6 | Per-receiver strobe: prepare the code of the sender in rx_src |
| rx_src | output | 18 | Per-receiver sender number to decode, 3 bits per receiver |

## Verification
A single request with the acknowledge held back, then released, pins the setup-to-grant latency and shows the wait on the receiver. Three senders aimed at one receiver in one cycle, then two more from the far side of the pointer, separate true round-robin from fixed priority. A late low-numbered sender queued behind an earlier high-numbered one separates arrival order from any pointer-based order. Three disjoint pairs raised together expose any coupling between destinations, and self-addressed or out-of-range destinations must leave every output quiet.

// File: rtl/csa_pkg.sv
package csa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_GRANT = 2'd2
    } port_state_e;

endpackage

// File: rtl/csa_req_decode.sv
module csa_req_decode #(
    parameter int N_NODES = 6,
    parameter int ID_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_NODES-1:0]                req_valid,
    input  logic [N_NODES*ID_W-1:0]           req_dest,
    output logic [N_NODES-1:0][N_NODES-1:0]   arrive_by_dest
);

    typedef struct packed {
        logic [N_NODES-1:0] inflight;
    } dec_t;

    dec_t s_d, s_q;
    logic [N_NODES-1:0] fresh;

    always_comb begin
        s_d = s_q;
        fresh = '0;
        arrive_by_dest = '0;
        for (int i = 0; i < N_NODES; i++) begin
            logic [ID_W-1:0] dst;
            dst = req_dest[i*ID_W +: ID_W];
            if (req_valid[i] && !s_q.inflight[i] &&
                (int'(dst) != i) && (int'(dst) < N_NODES)) begin
                fresh[i] = 1'b1;
            end
            for (int j = 0; j < N_NODES; j++) begin
                if (fresh[i] && (int'(dst) == j)) begin
                    arrive_by_dest[j][i] = 1'b1;
                end
            end
        end
        s_d.inflight = req_valid & (s_q.inflight | fresh);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/csa_dest_ctrl.sv
module csa_dest_ctrl
    import csa_pkg::*;
#(
    parameter int N_NODES = 6,
    parameter int ID_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_NODES-1:0] arrive,
    input  logic [N_NODES-1:0] req_valid,
    input  logic               rx_ack,
    output logic               rx_setup,
    output logic [ID_W-1:0]    rx_src,
    output logic [N_NODES-1:0] grant_vec
);

    localparam int DEPTH = N_NODES;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        port_state_e                  st;
        logic [ID_W-1:0]              owner;
        logic [ID_W-1:0]              last;
        logic [CNT_W-1:0]             cnt;
        logic [DEPTH-1:0][ID_W-1:0]   q;
    } ctrl_t;

    ctrl_t s_d, s_q;
    int    pos;
    int    idx;

    always_comb begin
        s_d = s_q;
        pos = 0;
        idx = 0;
        case (s_q.st)
            ST_IDLE: begin
                if (s_q.cnt != '0) begin
                    s_d.owner = s_q.q[0];
                    for (int e = 0; e < DEPTH - 1; e++) begin
                        s_d.q[e] = s_q.q[e+1];
                    end
                    s_d.q[DEPTH-1] = '0;
                    s_d.cnt = s_q.cnt - 1'b1;
                    s_d.st  = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (rx_ack) begin
                    s_d.st   = ST_GRANT;
                    s_d.last = s_q.owner;
                end
            end
            ST_GRANT: begin
                if (!req_valid[s_q.owner]) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        pos = int'(s_d.cnt);
        for (int k = 1; k <= N_NODES; k++) begin
            idx = (int'(s_q.last) + k) % N_NODES;
            if (arrive[idx] && (pos < DEPTH)) begin
                s_d.q[pos] = ID_W'(idx);
                pos = pos + 1;
            end
        end
        s_d.cnt = CNT_W'(pos);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.last <= ID_W'(N_NODES - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_setup = (s_q.st == ST_SETUP);
    assign rx_src   = s_q.owner;

    generate
        for (genvar g = 0; g < N_NODES; g++) begin : g_gnt
            assign grant_vec[g] = (s_q.st == ST_GRANT) && (s_q.owner == ID_W'(g));
        end
    endgenerate

endmodule

// File: rtl/csa_grant_merge.sv
module csa_grant_merge #(
    parameter int N_NODES = 6
) (
    input  logic [N_NODES-1:0][N_NODES-1:0] per_dest,
    output logic [N_NODES-1:0]              grant
);

    always_comb begin
        grant = '0;
        for (int j = 0; j < N_NODES; j++) begin
            grant = grant | per_dest[j];
        end
    end

endmodule

// File: rtl/code_setup_arbiter.sv
module code_setup_arbiter #(
    parameter  int N_NODES = 6,
    localparam int ID_W    = $clog2(N_NODES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_NODES-1:0]        req_valid,
    input  logic [N_NODES*ID_W-1:0]   req_dest,
    input  logic [N_NODES-1:0]        rx_ack,
    output logic [N_NODES-1:0]        grant,
    output logic [N_NODES-1:0]        rx_setup,
    output logic [N_NODES*ID_W-1:0]   rx_src
);

    logic [N_NODES-1:0][N_NODES-1:0] arrive_by_dest;
    logic [N_NODES-1:0][N_NODES-1:0] grant_by_dest;

    csa_req_decode #(
        .N_NODES (N_NODES),
        .ID_W    (ID_W)
    ) u_decode (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_dest       (req_dest),
        .arrive_by_dest (arrive_by_dest)
    );

    generate
        for (genvar j = 0; j < N_NODES; j++) begin : g_dest
            csa_dest_ctrl #(
                .N_NODES (N_NODES),
                .ID_W    (ID_W)
            ) u_ctrl (
                .clk       (clk),
                .rst_n     (rst_n),
                .arrive    (arrive_by_dest[j]),
                .req_valid (req_valid),
                .rx_ack    (rx_ack[j]),
                .rx_setup  (rx_setup[j]),
                .rx_src    (rx_src[j*ID_W +: ID_W]),
                .grant_vec (grant_by_dest[j])
            );
        end
    endgenerate

    csa_grant_merge #(
        .N_NODES (N_NODES)
    ) u_merge (
        .per_dest (grant_by_dest),
        .grant    (grant)
    );

endmodule

// File: rtl/code_setup_arbiter_chk.sv
module code_setup_arbiter_chk #(
    parameter int N_NODES = 6,
    parameter int ID_W    = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_NODES-1:0]      req_valid,
    input logic [N_NODES*ID_W-1:0] req_dest,
    input logic [N_NODES-1:0]      rx_ack,
    input logic [N_NODES-1:0]      grant,
    input logic [N_NODES-1:0]      rx_setup,
    input logic [N_NODES*ID_W-1:0] rx_src
);

    logic [N_NODES-1:0][N_NODES-1:0] live_to;

    always_comb begin
        live_to = '0;
        for (int j = 0; j < N_NODES; j++) begin
            for (int i = 0; i < N_NODES; i++) begin
                live_to[j][i] = grant[i] && req_valid[i] &&
                                (int'(req_dest[i*ID_W +: ID_W]) == j);
            end
        end
    end

    generate
        for (genvar i = 0; i < N_NODES; i++) begin : g_snd
            // R8: a grant only exists while the request was present the cycle before
            a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
                grant[i] |-> $past(req_valid[i]));
            // R9: a live grant never goes to a self or out-of-range destination
            a_r9_valid_target: assert property (@(posedge clk) disable iff (!rst_n)
                (grant[i] && req_valid[i]) |->
                ((int'(req_dest[i*ID_W +: ID_W]) != i) &&
                 (int'(req_dest[i*ID_W +: ID_W]) < N_NODES)));
            for (genvar j = 0; j < N_NODES; j++) begin : g_rcv
                // R2: a new grant follows an acknowledged setup naming this sender
                a_r2_grant_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
                    ($rose(grant[i]) && (int'(req_dest[i*ID_W +: ID_W]) == j)) |->
                    $past(rx_setup[j] && rx_ack[j] &&
                          (int'(rx_src[j*ID_W +: ID_W]) == i)));
            end
        end
        for (genvar j = 0; j < N_NODES; j++) begin : g_rx
            // R3: setup holds with a stable sender number until acknowledged
            a_r3_setup_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (rx_setup[j] && !rx_ack[j]) |=>
                (rx_setup[j] && $stable(rx_src[j*ID_W +: ID_W])));
            // R4: one sender per receiver
            a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(live_to[j]) <= 1);
        end
    endgenerate

endmodule

bind code_setup_arbiter code_setup_arbiter_chk #(
    .N_NODES (N_NODES),
    .ID_W    (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dest  (req_dest),
    .rx_ack    (rx_ack),
    .grant     (grant),
    .rx_setup  (rx_setup),
    .rx_src    (rx_src)
);

// File: tb/code_setup_arbiter_tb.sv
module code_setup_arbiter_tb;

    localparam int N   = 6;
    localparam int IDW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req_valid = '0;
    logic [N*IDW-1:0] req_dest = '0;
    logic [N-1:0]   ack_en = '1;
    logic [N-1:0]   rx_ack;
    logic [N-1:0]   grant;
    logic [N-1:0]   rx_setup;
    logic [N*IDW-1:0] rx_src;

    int checks = 0;
    int errors = 0;
    int got[N];
    int ngot;

    always #5 clk = ~clk;

    assign rx_ack = rx_setup & ack_en;

    code_setup_arbiter #(.N_NODES(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_dest  (req_dest),
        .rx_ack    (rx_ack),
        .grant     (grant),
        .rx_setup  (rx_setup),
        .rx_src    (rx_src)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic set_req(input int s, input int d, input bit v);
        req_dest[s*IDW +: IDW] = IDW'(d);
        req_valid[s] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Waits for grants among 'who', records order, checks hold and release
    task automatic collect(input logic [N-1:0] who, input int n);
        logic [N-1:0] g;
        int id;
        ngot = 0;
        for (int c = 0; c < 200 && ngot < n; c++) begin
            @(negedge clk);
            g = grant & who;
            if (g != '0) begin
                chk($countones(g) == 1, "R4 single grant", $countones(g), 1);
                id = 0;
                for (int b = 0; b < N; b++) if (g[b]) id = b;
                got[ngot] = id;
                ngot++;
                repeat (2) begin
                    @(negedge clk);
                    chk(grant[id] == 1'b1, "R8 grant held", int'(grant[id]), 1);
                end
                req_valid[id] = 1'b0;
                @(negedge clk);
                chk(grant[id] == 1'b0, "R8 grant dropped", int'(grant[id]), 0);
            end
        end
        chk(ngot == n, "R5/R6 grant count", ngot, n);
    endtask

    task automatic t_reset;
        chk(grant == '0, "R1 no grant", int'(grant), 0);
        chk(rx_setup == '0, "R1 no setup", int'(rx_setup), 0);
    endtask

    task automatic t_latency;
        ack_en = '0;
        set_req(0, 2, 1'b1);
        idle(2);
        chk(rx_setup[2] == 1'b1, "R2 setup after two edges", int'(rx_setup[2]), 1);
        chk(rx_src[2*IDW +: IDW] == 3'd0, "R2 sender number", int'(rx_src[2*IDW +: IDW]), 0);
        chk(grant == '0, "R2 no grant before ack", int'(grant), 0);
        idle(3);
        chk(rx_setup[2] == 1'b1, "R3 setup held", int'(rx_setup[2]), 1);
        chk(rx_src[2*IDW +: IDW] == 3'd0, "R3 sender stable", int'(rx_src[2*IDW +: IDW]), 0);
        chk(grant == '0, "R3 still no grant", int'(grant), 0);
        ack_en = '1;
        idle(1);
        chk(grant == 6'b000001, "R2 grant after ack", int'(grant), 1);
        chk(rx_setup[2] == 1'b0, "R2 setup cleared", int'(rx_setup[2]), 0);
        set_req(0, 2, 1'b0);
        idle(1);
        chk(grant == '0, "R8 release", int'(grant), 0);
        idle(2);
        // timed path with ack ready: grant after edge 3
        set_req(3, 4, 1'b1);
        idle(2);
        chk(grant == '0, "R2 no grant at edge 2", int'(grant), 0);
        idle(1);
        chk(grant[3] == 1'b1, "R2 grant at edge 3", int'(grant[3]), 1);
        set_req(3, 4, 1'b0);
        idle(2);
    endtask

    task automatic t_rr_same_cycle;
        set_req(1, 0, 1'b1);
        set_req(2, 0, 1'b1);
        set_req(4, 0, 1'b1);
        collect(6'b010110, 3);
        chk(got[0] == 1, "R5 first after reset pointer", got[0], 1);
        chk(got[1] == 2, "R5 second", got[1], 2);
        chk(got[2] == 4, "R5 third", got[2], 4);
        idle(2);
        // pointer now at 4: next round starts at 5, then wraps to 2
        set_req(2, 0, 1'b1);
        set_req(5, 0, 1'b1);
        collect(6'b100100, 2);
        chk(got[0] == 5, "R5 wrap first", got[0], 5);
        chk(got[1] == 2, "R5 wrap second", got[1], 2);
        idle(2);
    endtask

    task automatic t_fcfs;
        set_req(0, 3, 1'b1);
        idle(4);
        chk(grant[0] == 1'b1, "R6 owner granted", int'(grant[0]), 1);
        set_req(5, 3, 1'b1);
        idle(2);
        set_req(1, 3, 1'b1);
        idle(2);
        chk(grant == 6'b000001, "R4 waiters not granted", int'(grant), 1);
        set_req(0, 3, 1'b0);
        collect(6'b100010, 2);
        chk(got[0] == 5, "R6 earlier arrival first", got[0], 5);
        chk(got[1] == 1, "R6 later arrival second", got[1], 1);
        idle(2);
    endtask

    task automatic t_parallel;
        set_req(0, 1, 1'b1);
        set_req(2, 3, 1'b1);
        set_req(4, 5, 1'b1);
        idle(3);
        chk(grant == 6'b010101, "R7 all pairs same cycle", int'(grant), 21);
        req_valid = '0;
        idle(3);
    endtask

    task automatic t_ignored;
        set_req(3, 3, 1'b1);
        set_req(4, 6, 1'b1);
        set_req(5, 7, 1'b1);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c == 3 || c == 7) begin
                chk(grant == '0, "R9 no grant", int'(grant), 0);
                chk(rx_setup == '0, "R9 no setup", int'(rx_setup), 0);
            end
        end
        req_valid = '0;
        idle(2);
        // the same senders with valid targets still work afterwards
        set_req(4, 0, 1'b1);
        idle(3);
        chk(grant == 6'b010000, "R9 later valid request", int'(grant), 16);
        req_valid = '0;
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_latency();
        t_rr_same_cycle();
        t_fcfs();
        t_parallel();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule